// File: doc/BRIEF.md
# Layer 3/4 Header Match Filter

This block is one entry of a receive-side packet filter. A header parser upstream hands it the fields of a frame that it has already extracted: IP version, IP protocol number, source and destination IP addresses (up to 128 bits, with IPv4 addresses in the low 32 bits), and source and destination transport ports. These fields arrive together with a one-cycle valid strobe. The block compares them against reference values and a control word, all held in a small register file behind a simple write/read port. One cycle after each strobe it reports a Layer 3 verdict, a Layer 4 verdict, an overall verdict and a flag saying whether any criterion is armed.

Each address or port field can be ignored, matched exactly or matched inversely. A field matched inversely passes when it differs from its reference. Address fields can also drop a programmable number of low-order bits from the comparison. In IPv4 mode, source and destination each have their own 5-bit drop count. In IPv6 mode, a single 7-bit count is assembled from parts of both count fields. That count applies to just one address, and the destination address wins when both address enables are set.

Top module: `hdr_match_filter`

## Requirements
- R1: While `rst` is high at a clock edge, after that edge every register reads 0 and `res_valid`, `res_active`, `res_l3`, `res_l4`, `res_match` and `reg_rdata` are 0.
- R2: The control word is at register address 0. Writes to bits 31:22, 17 and 1 are discarded and those bits read 0. All other control bits are stored and read back as written.
- R3: `res_valid` is high exactly in the cycle after a cycle with `hdr_valid` high. The four result outputs update only on a strobe and hold their values otherwise.
- R4: With control bit 0 = 0 (IPv4), bit 2 enables the source address and bit 4 enables the destination address. The comparison covers address bits 31:0. Control bits 10:6 give the number of low source bits that are ignored, and bits 15:11 give the same for the destination (0 compares all 32 bits; N skips bits N-1:0).
- R5: Control bits 3 (source) and 5 (destination) select inverse matching, which passes when the compared bits differ. An inverse bit has no effect while its field enable is 0, and a disabled field always passes.
- R6: With control bit 0 = 1 (IPv6), the full 128-bit address is compared. The ignored low-bit count is the 7-bit value {ctrl[12:11], ctrl[10:6]}, so 127 compares only bit 127.
- R7: In IPv6 mode only one address is checked: the destination when bit 4 is set, otherwise the source. Its own inverse bit applies.
- R8: `res_l3` is 1 only when an address enable is set, `hdr_ipver` equals 4 (bit 0 = 0) or 6 (bit 0 = 1), and the checked addresses pass.
- R9: Control bits 18/19 enable and invert the source port, and bits 20/21 do the same for the destination port. Bit 16 chooses UDP (protocol number 17) when 1 and TCP (protocol number 6) when 0. `res_l4` is 1 only when a port enable is set, `hdr_proto` equals the chosen number, and both port fields pass.
- R10: `res_active` is 1 when any of bits 2, 4, 18 or 20 is set. `res_match` equals `res_active` AND (no address enable OR `res_l3`) AND (no port enable OR `res_l4`).
- R11: Register map: 1..4 hold reference source address words (address 1 holds bits 31:0), 5..8 hold reference destination address words, and 9 holds the source port in bits 15:0 and the destination port in bits 31:16. Addresses 10..15 read 0 and ignore writes. Reads return the addressed register one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address for write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data of `reg_addr` |
| hdr_valid | input | 1 | Header fields valid this cycle |
| hdr_ipver | input | 4 | IP version of the frame |
| hdr_proto | input | 8 | IP protocol number |
| hdr_sa | input | 128 | Source IP address (IPv4 in bits 31:0) |
| hdr_da | input | 128 | Destination IP address (IPv4 in bits 31:0) |
| hdr_sp | input | 16 | Source transport port |
| hdr_dp | input | 16 | Destination transport port |
| res_valid | output | 1 | Result valid, one cycle after strobe |
| res_active | output | 1 | Some criterion was armed |
| res_l3 | output | 1 | Layer 3 verdict |
| res_l4 | output | 1 | Layer 4 verdict |
| res_match | output | 1 | Combined verdict |

## Verification
The only state is the register file and the result register. A corrupted control or reference bit therefore appears at `reg_rdata` one cycle after that address is read. It also shows up in the verdict of the very next strobe that exercises the affected field. A wrong drop count or a mis-assembled IPv6 count only shows when a header differs from its reference inside the boundary band, so the stimulus deliberately flips bits on both sides of the programmed count. A stale result register is caught on the first idle cycle, through `res_valid` or the hold rule.

// File: rtl/hmf_pkg.sv
package hmf_pkg;

  // control word bit positions
  localparam int C_V6      = 0;
  localparam int C_SA_EN   = 2;
  localparam int C_SA_INV  = 3;
  localparam int C_DA_EN   = 4;
  localparam int C_DA_INV  = 5;
  localparam int C_SA_CNT  = 6;   // 5 bits
  localparam int C_DA_CNT  = 11;  // 5 bits
  localparam int C_UDP     = 16;
  localparam int C_SP_EN   = 18;
  localparam int C_SP_INV  = 19;
  localparam int C_DP_EN   = 20;
  localparam int C_DP_INV  = 21;

  localparam logic [31:0] CTRL_WMASK = 32'h003D_FFFD;

  localparam int V4_W      = 32;
  localparam int V4_CNT_W  = 5;
  localparam int V6_CNT_W  = 7;

  localparam logic [7:0] PROTO_TCP = 8'd6;
  localparam logic [7:0] PROTO_UDP = 8'd17;
  localparam logic [3:0] VER_4     = 4'd4;
  localparam logic [3:0] VER_6     = 4'd6;

  typedef struct packed {
    logic                v6;
    logic                sa_en;
    logic                sa_inv;
    logic                da_en;
    logic                da_inv;
    logic [V4_CNT_W-1:0] sa_cnt;
    logic [V4_CNT_W-1:0] da_cnt;
    logic [V6_CNT_W-1:0] v6_cnt;
    logic                udp;
    logic                sp_en;
    logic                sp_inv;
    logic                dp_en;
    logic                dp_inv;
  } ctrl_t;

  function automatic ctrl_t decode_ctrl(input logic [31:0] w);
    ctrl_t c;
    c.v6     = w[C_V6];
    c.sa_en  = w[C_SA_EN];
    c.sa_inv = w[C_SA_INV];
    c.da_en  = w[C_DA_EN];
    c.da_inv = w[C_DA_INV];
    c.sa_cnt = w[C_SA_CNT +: V4_CNT_W];
    c.da_cnt = w[C_DA_CNT +: V4_CNT_W];
    c.v6_cnt = {w[C_DA_CNT +: 2], w[C_SA_CNT +: V4_CNT_W]};
    c.udp    = w[C_UDP];
    c.sp_en  = w[C_SP_EN];
    c.sp_inv = w[C_SP_INV];
    c.dp_en  = w[C_DP_EN];
    c.dp_inv = w[C_DP_INV];
    return c;
  endfunction

endpackage

// File: rtl/hmf_regs.sv
module hmf_regs #(
  parameter int AW     = 4,
  parameter int IP_W   = 128,
  parameter int PORT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [AW-1:0]     addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic [31:0]       ctrl,
  output logic [IP_W-1:0]   sa_ref,
  output logic [IP_W-1:0]   da_ref,
  output logic [PORT_W-1:0] sp_ref,
  output logic [PORT_W-1:0] dp_ref
);
  import hmf_pkg::*;

  localparam int AWORDS  = IP_W / 32;
  localparam int SA_BASE = 1;
  localparam int DA_BASE = 1 + AWORDS;
  localparam int PT_IDX  = 1 + 2 * AWORDS;
  localparam int NREG    = PT_IDX + 1;

  logic [31:0] regs_q [NREG];
  logic [31:0] rd_word;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
    end else if (wr) begin
      for (int i = 0; i < NREG; i++)
        if (addr == AW'(i))
          regs_q[i] <= wdata & ((i == 0) ? CTRL_WMASK : 32'hFFFF_FFFF);
    end
  end

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < NREG; i++)
      if (addr == AW'(i)) rd_word = regs_q[i];
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_word;
  end

  assign ctrl = regs_q[0];

  for (genvar g = 0; g < AWORDS; g++) begin : g_addr
    assign sa_ref[32*g +: 32] = regs_q[SA_BASE + g];
    assign da_ref[32*g +: 32] = regs_q[DA_BASE + g];
  end

  assign sp_ref = regs_q[PT_IDX][0 +: PORT_W];
  assign dp_ref = regs_q[PT_IDX][16 +: PORT_W];

endmodule

// File: rtl/hmf_prefix_cmp.sv
module hmf_prefix_cmp #(
  parameter int W  = 32,
  parameter int CW = 5
) (
  input  logic [W-1:0]  fld,
  input  logic [W-1:0]  ref_val,
  input  logic [CW-1:0] skip,
  input  logic          en,
  input  logic          inv,
  output logic          pass
);
  logic [W-1:0] keep;
  logic         differ;

  assign keep   = {W{1'b1}} << skip;
  assign differ = |((fld ^ ref_val) & keep);
  assign pass   = !en || (inv ? differ : !differ);

endmodule

// File: rtl/hdr_match_filter.sv
module hdr_match_filter #(
  parameter int AW     = 4,
  parameter int IP_W   = 128,
  parameter int PORT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [AW-1:0]     reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              hdr_valid,
  input  logic [3:0]        hdr_ipver,
  input  logic [7:0]        hdr_proto,
  input  logic [IP_W-1:0]   hdr_sa,
  input  logic [IP_W-1:0]   hdr_da,
  input  logic [PORT_W-1:0] hdr_sp,
  input  logic [PORT_W-1:0] hdr_dp,
  output logic              res_valid,
  output logic              res_active,
  output logic              res_l3,
  output logic              res_l4,
  output logic              res_match
);
  import hmf_pkg::*;

  logic [31:0]       ctrl_q;
  logic [IP_W-1:0]   sa_ref, da_ref;
  logic [PORT_W-1:0] sp_ref, dp_ref;
  ctrl_t             c;

  hmf_regs #(.AW(AW), .IP_W(IP_W), .PORT_W(PORT_W)) u_regs (
    .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .ctrl(ctrl_q), .sa_ref(sa_ref), .da_ref(da_ref),
    .sp_ref(sp_ref), .dp_ref(dp_ref)
  );

  assign c = decode_ctrl(ctrl_q);

  // IPv4: two independent comparators on the low word
  logic sa4_pass, da4_pass;

  hmf_prefix_cmp #(.W(V4_W), .CW(V4_CNT_W)) u_sa4 (
    .fld(hdr_sa[V4_W-1:0]), .ref_val(sa_ref[V4_W-1:0]), .skip(c.sa_cnt),
    .en(c.sa_en), .inv(c.sa_inv), .pass(sa4_pass)
  );
  hmf_prefix_cmp #(.W(V4_W), .CW(V4_CNT_W)) u_da4 (
    .fld(hdr_da[V4_W-1:0]), .ref_val(da_ref[V4_W-1:0]), .skip(c.da_cnt),
    .en(c.da_en), .inv(c.da_inv), .pass(da4_pass)
  );

  // IPv6: one shared comparator, destination has priority
  logic [IP_W-1:0] v6_fld, v6_ref;
  logic            v6_inv, v6_pass;

  assign v6_fld = c.da_en ? hdr_da   : hdr_sa;
  assign v6_ref = c.da_en ? da_ref   : sa_ref;
  assign v6_inv = c.da_en ? c.da_inv : c.sa_inv;

  hmf_prefix_cmp #(.W(IP_W), .CW(V6_CNT_W)) u_a6 (
    .fld(v6_fld), .ref_val(v6_ref), .skip(c.v6_cnt),
    .en(c.sa_en | c.da_en), .inv(v6_inv), .pass(v6_pass)
  );

  // ports: identical comparators, built in a loop
  logic [PORT_W-1:0] pt_fld [2];
  logic [PORT_W-1:0] pt_ref [2];
  logic [1:0]        pt_en, pt_inv, pt_pass;

  assign pt_fld[0] = hdr_sp;  assign pt_ref[0] = sp_ref;
  assign pt_fld[1] = hdr_dp;  assign pt_ref[1] = dp_ref;
  assign pt_en  = {c.dp_en,  c.sp_en};
  assign pt_inv = {c.dp_inv, c.sp_inv};

  for (genvar p = 0; p < 2; p++) begin : g_port
    hmf_prefix_cmp #(.W(PORT_W), .CW(1)) u_pt (
      .fld(pt_fld[p]), .ref_val(pt_ref[p]), .skip(1'b0),
      .en(pt_en[p]), .inv(pt_inv[p]), .pass(pt_pass[p])
    );
  end

  // verdicts
  logic l3_en, l4_en, ver_ok, proto_ok, l3_hit, l4_hit, any_en, all_hit;

  assign l3_en    = c.sa_en | c.da_en;
  assign l4_en    = c.sp_en | c.dp_en;
  assign ver_ok   = hdr_ipver == (c.v6 ? VER_6 : VER_4);
  assign proto_ok = hdr_proto == (c.udp ? PROTO_UDP : PROTO_TCP);
  assign l3_hit   = l3_en & ver_ok & (c.v6 ? v6_pass : (sa4_pass & da4_pass));
  assign l4_hit   = l4_en & proto_ok & (&pt_pass);
  assign any_en   = l3_en | l4_en;
  assign all_hit  = any_en & (!l3_en | l3_hit) & (!l4_en | l4_hit);

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid  <= 1'b0;
      res_active <= 1'b0;
      res_l3     <= 1'b0;
      res_l4     <= 1'b0;
      res_match  <= 1'b0;
    end else begin
      res_valid <= hdr_valid;
      if (hdr_valid) begin
        res_active <= any_en;
        res_l3     <= l3_hit;
        res_l4     <= l4_hit;
        res_match  <= all_hit;
      end
    end
  end

endmodule

// File: rtl/hmf_checker.sv
module hmf_checker (
  input logic        clk,
  input logic        rst,
  input logic [3:0]  reg_addr,
  input logic [31:0] reg_rdata,
  input logic [31:0] ctrl,
  input logic        hdr_valid,
  input logic        res_valid,
  input logic        res_active,
  input logic        res_l3,
  input logic        res_l4,
  input logic        res_match
);
  import hmf_pkg::*;

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!res_valid && !res_active && !res_match && reg_rdata == 32'd0));

  // R2
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
    $past(reg_addr) == 4'd0 |-> (reg_rdata & ~CTRL_WMASK) == 32'd0);

  // R3
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    hdr_valid |=> res_valid);

  // R3
  valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !hdr_valid |=> !res_valid);

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !hdr_valid |=> ($stable(res_match) && $stable(res_l3) &&
                    $stable(res_l4) && $stable(res_active)));

  // R10
  match_active_chk: assert property (@(posedge clk) disable iff (rst)
    res_match |-> res_active);

  // R10
  match_needs_l3_chk: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_match && $past(ctrl[C_SA_EN] | ctrl[C_DA_EN])) |-> res_l3);

  // R10
  match_needs_l4_chk: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_match && $past(ctrl[C_SP_EN] | ctrl[C_DP_EN])) |-> res_l4);

endmodule

bind hdr_match_filter hmf_checker u_chk (
  .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
  .ctrl(ctrl_q), .hdr_valid(hdr_valid), .res_valid(res_valid),
  .res_active(res_active), .res_l3(res_l3), .res_l4(res_l4),
  .res_match(res_match)
);

// File: tb/hdr_match_filter_bench.sv
module hdr_match_filter_bench;
  localparam time CLK_PERIOD = 10ns;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         reg_wr = 1'b0;
  logic [3:0]   reg_addr = '0;
  logic [31:0]  reg_wdata = '0;
  logic [31:0]  reg_rdata;
  logic         hdr_valid = 1'b0;
  logic [3:0]   hdr_ipver = '0;
  logic [7:0]   hdr_proto = '0;
  logic [127:0] hdr_sa = '0, hdr_da = '0;
  logic [15:0]  hdr_sp = '0, hdr_dp = '0;
  logic         res_valid, res_active, res_l3, res_l4, res_match;

  hdr_match_filter u_hdr_match_filter (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hdr_valid(hdr_valid),
    .hdr_ipver(hdr_ipver), .hdr_proto(hdr_proto), .hdr_sa(hdr_sa),
    .hdr_da(hdr_da), .hdr_sp(hdr_sp), .hdr_dp(hdr_dp),
    .res_valid(res_valid), .res_active(res_active), .res_l3(res_l3),
    .res_l4(res_l4), .res_match(res_match)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  // ---------------- reference model ----------------
  bit [31:0] m_reg [16];
  bit [31:0] e_rdata;
  bit        e_valid, e_active, e_l3, e_l4, e_match;

  function automatic bit writable(int b);
    return !(b >= 22 || b == 17 || b == 1);   // R2
  endfunction

  function automatic bit field_ok(bit [127:0] a, bit [127:0] r, int w, int skip,
                                  bit en, bit inv);
    bit same = 1;
    if (!en) return 1;                                   // R5
    for (int i = skip; i < w; i++) if (a[i] != r[i]) same = 0;
    return inv ? !same : same;
  endfunction

  always @(posedge clk) begin
    bit [31:0] cw;
    bit [127:0] rsa, rda;
    bit l3e, l4e, a_ok, p_ok, h3, h4;
    int c6;
    cw  = m_reg[0];
    rsa = {m_reg[4], m_reg[3], m_reg[2], m_reg[1]};      // R11
    rda = {m_reg[8], m_reg[7], m_reg[6], m_reg[5]};
    if (rst) begin                                       // R1
      e_rdata = 0; e_valid = 0; e_active = 0; e_l3 = 0; e_l4 = 0; e_match = 0;
      for (int i = 0; i < 16; i++) m_reg[i] = 0;
    end else begin
      e_rdata = (reg_addr <= 9) ? m_reg[reg_addr] : 0;
      e_valid = hdr_valid;
      if (hdr_valid) begin
        l3e = cw[2] | cw[4];
        l4e = cw[18] | cw[20];
        if (!cw[0]) begin                                // R4
          a_ok = field_ok(hdr_sa, rsa, 32, int'(cw[10:6]), cw[2], cw[3]) &&
                 field_ok(hdr_da, rda, 32, int'(cw[15:11]), cw[4], cw[5]);
          h3 = l3e && hdr_ipver == 4 && a_ok;            // R8
        end else begin                                   // R6, R7
          c6 = int'(cw[12:11]) * 32 + int'(cw[10:6]);
          if (cw[4]) a_ok = field_ok(hdr_da, rda, 128, c6, 1, cw[5]);
          else       a_ok = field_ok(hdr_sa, rsa, 128, c6, cw[2], cw[3]);
          h3 = l3e && hdr_ipver == 6 && a_ok;
        end
        p_ok = field_ok({112'd0, hdr_sp}, {112'd0, m_reg[9][15:0]}, 16, 0, cw[18], cw[19]) &&
               field_ok({112'd0, hdr_dp}, {112'd0, m_reg[9][31:16]}, 16, 0, cw[20], cw[21]);
        h4 = l4e && hdr_proto == (cw[16] ? 17 : 6) && p_ok;   // R9
        e_active = l3e | l4e;                                 // R10
        e_l3 = h3; e_l4 = h4;
        e_match = (l3e | l4e) && (!l3e || h3) && (!l4e || h4);
      end
      if (reg_wr && reg_addr <= 9) begin                 // R11: 10..15 ignored
        for (int b = 0; b < 32; b++)
          m_reg[reg_addr][b] = (reg_addr == 0 && !writable(b)) ? 1'b0 : reg_wdata[b];
      end
    end
  end

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s at %0t: actual %h expected %h", req, what, $time, act, exp);
    end
  endtask

  // compare on every falling edge
  always @(negedge clk) begin
    if (!finished) begin
      chk("R11", "reg_rdata", reg_rdata, e_rdata);
      chk("R3",  "res_valid", {31'd0, res_valid}, {31'd0, e_valid});
      chk("R10", "res_active", {31'd0, res_active}, {31'd0, e_active});
      chk("R8",  "res_l3", {31'd0, res_l3}, {31'd0, e_l3});
      chk("R9",  "res_l4", {31'd0, res_l4}, {31'd0, e_l4});
      chk("R10", "res_match", {31'd0, res_match}, {31'd0, e_match});
    end
  end

  // ---------------- stimulus ----------------
  task automatic wreg(int a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = 4'(a); reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rreg(int a);
    @(negedge clk);
    reg_addr = 4'(a);
    @(negedge clk);
  endtask

  task automatic hdr(int ver, int pr, logic [127:0] sa, logic [127:0] da,
                     logic [15:0] sp, logic [15:0] dp);
    @(negedge clk);
    hdr_valid = 1; hdr_ipver = 4'(ver); hdr_proto = 8'(pr);
    hdr_sa = sa; hdr_da = da; hdr_sp = sp; hdr_dp = dp;
    @(negedge clk);
    hdr_valid = 0;
  endtask

  localparam logic [127:0] SA6 = 128'h2001_0db8_aaaa_0001_0000_0000_0000_1234;
  localparam logic [127:0] DA6 = 128'hfe80_0000_0000_0000_0202_b3ff_fe1e_8329;

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    // R1, R11: everything reads zero after reset
    for (int a = 0; a < 16; a++) rreg(a);
    // R2: reserved control bits
    wreg(0, 32'hFFFF_FFFF); rreg(0);
    wreg(0, 32'h0); rreg(0);
    // R11: unmapped address ignores writes
    wreg(12, 32'hDEAD_BEEF); rreg(12);
    // program IPv4 references and ports
    wreg(1, 32'h0A00_0001); wreg(5, 32'hC0A8_0101);
    wreg(9, {16'd80, 16'd1234});
    for (int a = 0; a < 10; a++) rreg(a);
    // R4: IPv4 exact match both addresses
    wreg(0, 32'h0000_0014);
    hdr(4, 6, 128'h0A00_0001, 128'hC0A8_0101, 0, 0);
    hdr(4, 6, 128'h0A00_0000, 128'hC0A8_0101, 0, 0);
    // R4: skip 8 source bits, 4 destination bits
    wreg(0, (32'd4 << 11) | (32'd8 << 6) | 32'h14);
    hdr(4, 6, 128'h0A00_00FF, 128'hC0A8_010E, 0, 0);
    hdr(4, 6, 128'h0A00_01FF, 128'hC0A8_0101, 0, 0);
    hdr(4, 6, 128'h0A00_0001, 128'hC0A8_0111, 0, 0);
    // R4: count 31 compares only MSB
    wreg(0, (32'd31 << 11) | 32'h10);
    hdr(4, 6, 0, 128'hC000_0000, 0, 0);
    hdr(4, 6, 0, 128'h4000_0000, 0, 0);
    // R5: inverse destination; inverse ignored when disabled
    wreg(0, 32'h0000_0034);
    hdr(4, 6, 128'h0A00_0001, 128'hC0A8_0102, 0, 0);
    hdr(4, 6, 128'h0A00_0001, 128'hC0A8_0101, 0, 0);
    wreg(0, 32'h0000_0018);
    hdr(4, 6, 128'h0A00_0001, 128'h1111_1111, 0, 0);
    // R8: wrong version
    wreg(0, 32'h0000_0014);
    hdr(6, 6, 128'h0A00_0001, 128'hC0A8_0101, 0, 0);
    // R9: TCP ports, UDP ports, inverse port
    wreg(0, 32'h0014_0000);
    hdr(4, 6, 0, 0, 1234, 80);
    hdr(4, 17, 0, 0, 1234, 80);
    wreg(0, 32'h0015_0000);
    hdr(4, 17, 0, 0, 1234, 80);
    hdr(4, 17, 0, 0, 1234, 81);
    wreg(0, 32'h000C_0000);
    hdr(4, 6, 0, 0, 1235, 80);
    hdr(4, 6, 0, 0, 1234, 80);
    // R10: combined layers and nothing armed
    wreg(0, 32'h0014_0014);
    hdr(4, 6, 128'h0A00_0001, 128'hC0A8_0101, 1234, 80);
    hdr(4, 6, 128'h0A00_0001, 128'hC0A8_0101, 1234, 99);
    wreg(0, 32'h0);
    hdr(4, 6, 0, 0, 0, 0);
    // R6, R7: IPv6 references
    for (int w = 0; w < 4; w++) begin
      wreg(1 + w, SA6[32*w +: 32]);
      wreg(5 + w, DA6[32*w +: 32]);
    end
    wreg(0, 32'h0000_0005);                           // source only
    hdr(6, 6, SA6, 0, 0, 0);
    hdr(6, 6, SA6 ^ 128'h1, 0, 0, 0);
    wreg(0, 32'h0000_0015);                           // both set: destination wins
    hdr(6, 6, 0, DA6, 0, 0);
    hdr(6, 6, SA6, DA6 ^ (128'h1 << 100), 0, 0);
    // R6: count 64 = {2'b10, 5'd0}
    wreg(0, (32'd2 << 11) | 32'h11);
    hdr(6, 6, 0, DA6 ^ (128'h1 << 63), 0, 0);
    hdr(6, 6, 0, DA6 ^ (128'h1 << 64), 0, 0);
    // R6: count 127 compares bit 127 only
    wreg(0, (32'd3 << 11) | (32'd31 << 6) | 32'h11);
    hdr(6, 6, 0, {1'b1, 127'd0}, 0, 0);
    hdr(6, 6, 0, 128'h1, 0, 0);
    // mixed patterns near the references
    for (int k = 0; k < 400; k++) begin
      logic [127:0] sa, da;
      logic [31:0]  cw;
      int fb;
      if (k % 8 == 0) begin
        cw = $urandom;
        wreg(0, cw);
      end
      sa = ($urandom % 2) ? SA6 : {96'd0, 32'(SA6[31:0])};
      da = ($urandom % 2) ? DA6 : {96'd0, 32'(DA6[31:0])};
      fb = int'($urandom % 128);
      if ($urandom % 2) sa[fb] = ~sa[fb];
      fb = int'($urandom % 128);
      if ($urandom % 2) da[fb] = ~da[fb];
      hdr(($urandom % 2) ? 6 : 4, ($urandom % 3 == 0) ? 17 : 6, sa, da,
          16'(($urandom % 2) ? 16'h1234 : 16'($urandom)),
          16'(($urandom % 2) ? 16'h0202 : 16'($urandom)));
      if (k % 50 == 0) rreg(int'($urandom % 16));
    end
    repeat (3) @(negedge clk);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      finished = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog: run did not complete");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
      $finish;
    end
  end

endmodule